// File: doc/BRIEF.md
# Multi-Mode Dual Timer/Counter

This block holds two timer/counter channels. Each channel stores its count in two byte registers, a low byte and a high byte, and software can read and write both. One shared 8-bit configuration register sets up both channels. For each channel it selects the count source, the external gating and one of four counting structures: 13-bit, 16-bit, 8-bit with reload from the high byte, or split operation. In split operation channel 0 becomes two independent 8-bit timers.

A channel counts either clock cycles or falling edges on its event pin. The event pin is synchronized before use. A channel advances only while its run input is high. When gating is enabled, the synchronized gate pin must also be high. Each overflow sets a sticky flag output, and a clear input drops the flag. Registers are reached through one address bus. A write strobe stores a value, and the read data port returns the addressed register combinationally. The run, gate, event, clear and flag pins are plain levels with no handshake.

Top module: `dual_timer`

## Requirements
- R1: After reset, all five registers read 0x00 and both flag outputs are low.
- R2: Address 0 is the configuration register, 1 is channel 0 low byte, 2 is channel 0 high byte, 3 is channel 1 low byte and 4 is channel 1 high byte. Every register reads back what was written. Addresses 5 to 7 read 0x00, and writes to them change nothing.
- R3: Configuration bits 3:0 set up channel 0 and bits 7:4 set up channel 1. Within a nibble, bit 3 enables gating, bit 2 selects event counting (1) over clock counting (0), and bits 1:0 pick the mode: 0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = split.
- R4: A channel advances only while its run input is high and, with gating enabled, its gate pin (synchronized over two clocks) is high. Otherwise the count holds. In clock counting it advances by one per clock.
- R5: Mode 0 counts a 13-bit value. The low 5 bits of the low byte carry into the high byte. Low-byte bits 7:5 never change while counting. Wrapping from 0x1FFF to 0 is an overflow.
- R6: Mode 1 counts {high,low} as 16 bits. Wrapping from 0xFFFF to 0x0000 is an overflow.
- R7: Mode 2 counts the low byte only. When the low byte advances from 0xFF, it loads the high byte and overflows. The high byte stays unchanged.
- R8: With channel 0 in mode 3, its low byte is an 8-bit timer that uses run0 and flag0. Its high byte is an 8-bit clock timer that uses run1 and sets flag1. During this time an overflow of channel 1 does not set flag1.
- R9: Channel 1 in mode 3 holds its count.
- R10: In event counting, the count advances once per 1-to-0 transition of the event pin. A steady pin level does not advance the count.
- R11: An overflow sets the channel's flag, and the flag stays set until its clear input is high. If a set and a clear happen in the same cycle, the set wins.
- R12: A write to either byte of a channel takes that cycle's place for the channel: the written value is stored and nothing counts. Counting resumes on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| run0 | input | 1 | Run control, channel 0 |
| run1 | input | 1 | Run control, channel 1 (and the split high timer) |
| gate0 | input | 1 | Gate level pin, channel 0 |
| gate1 | input | 1 | Gate level pin, channel 1 |
| evt0 | input | 1 | Event pin, channel 0 |
| evt1 | input | 1 | Event pin, channel 1 |
| clr0 | input | 1 | Clear flag 0 |
| clr1 | input | 1 | Clear flag 1 |
| flag0 | output | 1 | Overflow flag, channel 0 |
| flag1 | output | 1 | Overflow flag, channel 1 |

## Verification
The bench sweeps modes 0 to 2 on both channels. It uses start values near the wrap points and run lengths of 1, 37 and 300 cycles, and compares each result with arithmetic on the 13-bit, 16-bit or reload structure. A design that let mode 0 carry into bits 7:5, or that reloaded from the wrong byte, would land on a wrong count after the wrap. Split mode is checked for flag routing: a design that let channel 1's own wrap set flag1 would raise the flag when it should stay low. Further cases cover a write colliding with counting, a set colliding with a clear, steady event levels, and gating held low. A design that lost a write, counted level rather than falling edges, or ignored the gate pin would show a count off by one or more.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;
  localparam int ADDR_W = 3;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    CM_13    = 2'd0,
    CM_16    = 2'd1,
    CM_8R    = 2'd2,
    CM_SPLIT = 2'd3
  } cnt_mode_e;

  typedef struct packed {
    logic      gate_en;
    logic      evt_src;
    cnt_mode_e mode;
  } chan_cfg_t;

  localparam logic [ADDR_W-1:0] A_CFG = 3'd0;
  localparam logic [ADDR_W-1:0] A_LO0 = 3'd1;
  localparam logic [ADDR_W-1:0] A_HI0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_LO1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_HI1 = 3'd4;
endpackage

// File: rtl/dtc_sync.sv
module dtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/dtc_src.sv
module dtc_src
  import dtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  chan_cfg_t cfg,
  input  logic      run,
  input  logic      gate_pin,
  input  logic      evt_pin,
  output logic      adv
);
  logic gate_s, evt_s, evt_prev, fall, gate_ok, tick;

  dtc_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .din(gate_pin), .dout(gate_s));
  dtc_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
    .clk(clk), .rst_n(rst_n), .din(evt_pin), .dout(evt_s));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) evt_prev <= 1'b0;
    else        evt_prev <= evt_s;

  assign fall    = evt_prev & ~evt_s;
  assign gate_ok = ~cfg.gate_en | gate_s;
  assign tick    = cfg.evt_src ? fall : 1'b1;
  assign adv     = run & gate_ok & tick;

  // R10: an event-mode advance needs a falling edge
  a_r10_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.evt_src && adv) |-> (evt_prev && !evt_s));
  // R4: no advance without run
  a_r4_run_needed: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !adv);
endmodule

// File: rtl/dtc_core.sv
module dtc_core
  import dtc_pkg::*;
#(
  parameter bit SPLIT_CAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cnt_mode_e         mode,
  input  logic              adv,
  input  logic              adv_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              ovf_lo,
  output logic              ovf_hi
);
  localparam int FULL_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] nxt_lo, nxt_hi;
  logic [PRE_W:0]    pre_sum;
  logic [BYTE_W:0]   lo_sum, hi_sum;
  logic [FULL_W:0]   full_sum;
  logic              ovf_c, ovfh_c, blocked;

  assign blocked  = wr_lo | wr_hi;
  assign pre_sum  = {1'b0, lo[PRE_W-1:0]} + 1'b1;
  assign lo_sum   = {1'b0, lo} + 1'b1;
  assign hi_sum   = {1'b0, hi} + 1'b1;
  assign full_sum = {1'b0, hi, lo} + 1'b1;

  always_comb begin
    nxt_lo = lo;
    nxt_hi = hi;
    ovf_c  = 1'b0;
    ovfh_c = 1'b0;
    case (mode)
      CM_13: if (adv) begin
        nxt_lo = {lo[BYTE_W-1:PRE_W], pre_sum[PRE_W-1:0]};
        if (pre_sum[PRE_W]) begin
          nxt_hi = hi_sum[BYTE_W-1:0];
          ovf_c  = hi_sum[BYTE_W];
        end
      end
      CM_16: if (adv) begin
        {nxt_hi, nxt_lo} = full_sum[FULL_W-1:0];
        ovf_c = full_sum[FULL_W];
      end
      CM_8R: if (adv) begin
        if (lo_sum[BYTE_W]) begin
          nxt_lo = hi;
          ovf_c  = 1'b1;
        end else begin
          nxt_lo = lo_sum[BYTE_W-1:0];
        end
      end
      CM_SPLIT: if (SPLIT_CAP) begin
        if (adv) begin
          nxt_lo = lo_sum[BYTE_W-1:0];
          ovf_c  = lo_sum[BYTE_W];
        end
        if (adv_hi) begin
          nxt_hi = hi_sum[BYTE_W-1:0];
          ovfh_c = hi_sum[BYTE_W];
        end
      end
      default: ;
    endcase
    if (blocked) begin
      ovf_c  = 1'b0;
      ovfh_c = 1'b0;
      nxt_lo = wr_lo ? wr_data : lo;
      nxt_hi = wr_hi ? wr_data : hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= nxt_lo;
      hi <= nxt_hi;
    end

  assign ovf_lo = ovf_c;
  assign ovf_hi = ovfh_c;

  // R4: idle channel holds both bytes
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !adv_hi && !blocked) |=> ($stable(lo) && $stable(hi)));
  // R5: prescaler mode never alters the upper low-byte bits
  a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_13 && !wr_lo) |=> (lo[BYTE_W-1:PRE_W] == $past(lo[BYTE_W-1:PRE_W])));
  // R7: reload takes the high byte
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_8R && ovf_lo) |=> (lo == $past(hi) && $stable(hi)));
  // R12: a write lands unchanged
  a_r12_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo == $past(wr_data)));

  generate
    if (!SPLIT_CAP) begin : g_no_split
      // R9: split request on the second channel freezes it
      a_r9_split_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_SPLIT && !blocked) |=> ($stable(lo) && $stable(hi)));
    end
  endgenerate
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              run0,
  input  logic              run1,
  input  logic              gate0,
  input  logic              gate1,
  input  logic              evt0,
  input  logic              evt1,
  input  logic              clr0,
  input  logic              clr1,
  output logic              flag0,
  output logic              flag1
);
  localparam int NCH = 2;

  logic [BYTE_W-1:0] cfg_q;
  chan_cfg_t         cfg   [NCH];
  logic              run_v [NCH];
  logic              gate_v[NCH];
  logic              evt_v [NCH];
  logic              adv   [NCH];
  logic              ovl   [NCH];
  logic              ovh   [NCH];
  logic [BYTE_W-1:0] lo    [NCH];
  logic [BYTE_W-1:0] hi    [NCH];
  logic              split0, set0, set1;

  assign cfg[0] = chan_cfg_t'(cfg_q[3:0]);
  assign cfg[1] = chan_cfg_t'(cfg_q[7:4]);
  assign run_v[0] = run0;  assign run_v[1] = run1;
  assign gate_v[0] = gate0; assign gate_v[1] = gate1;
  assign evt_v[0] = evt0;  assign evt_v[1] = evt1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      cfg_q <= '0;
    else if (wr_en && addr == A_CFG) cfg_q <= wr_data;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic wl, wh;
      assign wl = wr_en && (addr == ADDR_W'(2*c + 1));
      assign wh = wr_en && (addr == ADDR_W'(2*c + 2));

      dtc_src u_src (
        .clk(clk), .rst_n(rst_n), .cfg(cfg[c]), .run(run_v[c]),
        .gate_pin(gate_v[c]), .evt_pin(evt_v[c]), .adv(adv[c]));

      dtc_core #(.SPLIT_CAP(c == 0)) u_core (
        .clk(clk), .rst_n(rst_n), .mode(cfg[c].mode), .adv(adv[c]),
        .adv_hi((c == 0) ? run1 : 1'b0), .wr_lo(wl), .wr_hi(wh),
        .wr_data(wr_data), .lo(lo[c]), .hi(hi[c]),
        .ovf_lo(ovl[c]), .ovf_hi(ovh[c]));
    end
  endgenerate

  assign split0 = (cfg[0].mode == CM_SPLIT);
  assign set0   = ovl[0];
  assign set1   = split0 ? ovh[0] : (ovl[1] | ovh[1]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag0 <= 1'b0;
      flag1 <= 1'b0;
    end else begin
      flag0 <= set0 | (flag0 & ~clr0);
      flag1 <= set1 | (flag1 & ~clr1);
    end

  always_comb begin
    case (addr)
      A_CFG:   rd_data = cfg_q;
      A_LO0:   rd_data = lo[0];
      A_HI0:   rd_data = hi[0];
      A_LO1:   rd_data = lo[1];
      A_HI1:   rd_data = hi[1];
      default: rd_data = '0;
    endcase
  end

  // R11: an overflow always leaves the flag high
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set0 |=> flag0);
  // R11: flag sticks without clear
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag1 && !clr1) |=> flag1);
  // R8: in split operation channel 1's own wrap leaves flag1 alone
  a_r8_flag_route: assert property (@(posedge clk) disable iff (!rst_n)
    (split0 && !flag1 && !ovh[0]) |=> !flag1);
  // R2: configuration write is stored
  a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CFG) |=> (cfg_q == $past(wr_data)));
endmodule

// File: tb/tb_dual_timer.sv
module tb_dual_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic run0 = 0, run1 = 0, gate0 = 0, gate1 = 0, evt0 = 1, evt1 = 1, clr0 = 0, clr1 = 0;
  logic flag0, flag1;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_timer dut (.*);

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr = 3'(a);
    #1 v = int'(rd_data);
  endtask

  task automatic run_ch(input int ch, input int n);
    @(negedge clk);
    if (ch == 0) run0 = 1; else run1 = 1;
    repeat (n) @(negedge clk);
    run0 = 0; run1 = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); clr0 = 1; clr1 = 1;
    @(negedge clk); clr0 = 0; clr1 = 0;
  endtask

  task automatic model(input int mode, input int lo, input int hi, input int n,
                       output int elo, output int ehi, output int ovf);
    int v, rem, per;
    ovf = 0; elo = lo; ehi = hi;
    if (mode == 0) begin
      v = hi * 32 + (lo % 32) + n;
      ovf = v / 8192; v = v % 8192;
      ehi = v / 32; elo = (lo / 32) * 32 + (v % 32);
    end else if (mode == 1) begin
      v = hi * 256 + lo + n;
      ovf = v / 65536; v = v % 65536;
      ehi = v / 256; elo = v % 256;
    end else begin
      if (n < 256 - lo) elo = lo + n;
      else begin
        rem = n - (256 - lo); per = 256 - hi;
        elo = hi + rem % per; ovf = 1 + rem / per;
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int v, elo, ehi, ovf, lo, hi;
    int nl[3] = '{1, 37, 300};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin rd(a, v); chk("R1 reg", v, 0); end
    chk("R1 flag0", int'(flag0), 0);
    chk("R1 flag1", int'(flag1), 0);
    // R2 map and readback
    wr(0, 8'h21); rd(0, v); chk("R2 cfg readback", v, 8'h21);
    wr(4, 8'h5A); rd(4, v); chk("R2 hi1 readback", v, 8'h5A);
    wr(5, 8'hFF); rd(5, v); chk("R2 unmapped read", v, 0);
    rd(0, v); chk("R2 unmapped write ignored", v, 8'h21);
    // R3 R5 R6 R7 R11 mode sweep on both channels
    for (int ch = 0; ch < 2; ch++)
      for (int m = 0; m < 3; m++)
        for (int s = 0; s < 4; s++)
          for (int k = 0; k < 3; k++) begin
            lo = (s * 70 + 200) % 256;
            hi = (s % 2) ? 8'hFF : 8'h12;
            wr(0, (ch == 0) ? m : m * 16);
            wr(1 + 2 * ch, lo); wr(2 + 2 * ch, hi);
            clear_flags();
            run_ch(ch, nl[k]);
            model(m, lo, hi, nl[k], elo, ehi, ovf);
            rd(1 + 2 * ch, v);
            chk(m == 0 ? "R5 lo" : m == 1 ? "R6 lo" : "R7 lo", v, elo);
            rd(2 + 2 * ch, v);
            chk(m == 0 ? "R5 hi" : m == 1 ? "R6 hi" : "R7 hi", v, ehi);
            chk("R11 flag", int'(ch == 0 ? flag0 : flag1), int'(ovf > 0));
          end
    // R11 flag stays without clear, set beats clear
    wr(0, 8'h01); wr(1, 8'hFF); wr(2, 8'hFF); clear_flags();
    @(negedge clk); run0 = 1; clr0 = 1;
    @(negedge clk); run0 = 0; clr0 = 0;
    chk("R11 set wins over clear", int'(flag0), 1);
    repeat (5) @(negedge clk);
    chk("R11 sticky", int'(flag0), 1);
    // R12 write during counting
    wr(1, 0); wr(2, 0);
    @(negedge clk); run0 = 1;
    repeat (5) @(negedge clk);
    wr_en = 1; addr = 3'd1; wr_data = 8'h80;
    @(negedge clk); wr_en = 0;
    repeat (3) @(negedge clk);
    run0 = 0;
    rd(1, v); chk("R12 write then count", v, 8'h83);
    // R4 gating on channel 1
    wr(0, 8'h90); wr(3, 0); wr(4, 0); gate1 = 0;
    repeat (4) @(negedge clk);
    run_ch(1, 20); rd(3, v); chk("R4 gate low holds", v, 0);
    gate1 = 1; repeat (4) @(negedge clk);
    run_ch(1, 20); rd(3, v); chk("R4 gate high counts", v, 20);
    gate1 = 0;
    // R10 event counting on channel 0
    wr(0, 8'h05); wr(1, 0); wr(2, 0);
    @(negedge clk); run0 = 1;
    for (int p = 0; p < 7; p++) begin
      evt0 = 0; repeat (3) @(negedge clk);
      evt0 = 1; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    rd(1, v); chk("R10 seven falling edges", v, 7);
    repeat (20) @(negedge clk);
    rd(1, v); chk("R10 steady level no count", v, 7);
    run0 = 0;
    for (int p = 0; p < 4; p++) begin
      evt0 = 0; repeat (3) @(negedge clk);
      evt0 = 1; repeat (3) @(negedge clk);
    end
    rd(1, v); chk("R4 edges without run ignored", v, 7);
    // R8 split mode
    wr(0, 8'h13); wr(1, 8'hFE); wr(2, 8'hF0); wr(3, 0); wr(4, 0);
    clear_flags();
    run_ch(0, 3);
    rd(1, v); chk("R8 split low", v, 8'h01);
    rd(2, v); chk("R8 split high untouched by run0", v, 8'hF0);
    chk("R8 flag0", int'(flag0), 1);
    chk("R8 flag1 low", int'(flag1), 0);
    run_ch(1, 20);
    rd(2, v); chk("R8 split high wraps", v, 8'h04);
    chk("R8 flag1 set", int'(flag1), 1);
    rd(3, v); chk("R8 ch1 keeps counting", v, 8'h14);
    clear_flags();
    wr(3, 8'hFF); wr(4, 8'hFF);
    run_ch(1, 1);
    rd(3, v); chk("R8 ch1 wraps", v, 0);
    rd(2, v); chk("R8 split high step", v, 8'h05);
    chk("R8 ch1 wrap leaves flag1", int'(flag1), 0);
    // R9 channel 1 in split holds
    wr(0, 8'h30); wr(3, 8'h55); wr(4, 8'hAA);
    run_ch(1, 10);
    rd(3, v); chk("R9 lo hold", v, 8'h55);
    rd(4, v); chk("R9 hi hold", v, 8'hAA);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule